// File: doc/BRIEF.md
# Serial Flash Bulk-Erase Command Unit

This block is the slave-side command decoder of a serial flash device, cut down to three operations: setting the write-enable latch, erasing the whole array, and reading the status byte. It samples chip select, serial clock and serial data with the system clock and shifts opcodes in on serial-clock rising edges. When chip select returns high, it executes the captured command.

A bulk erase runs only if four conditions hold: the write-enable latch is already set, no protect bit is set, no erase is running, and chip select rose after exactly eight bits. The accepted erase then runs a self-timed cycle counted in system clocks. For that whole cycle a strobe forces every byte of a small internal array to all ones. The write-enable latch drops on the first count of the cycle. The status byte can be polled over the serial interface while the erase runs. A debug read port shows array contents, and `erase_busy` shows the erase strobe.

Top module: `flash_bulk_erase_unit`

## Requirements
- R1: After reset, the status byte reads 00h (with protect input 000), `erase_busy` is 0, and array byte i holds (37*i+3) mod 256.
- R2: While `cs_n` is low, opcode bits are taken from `dq_in` on `sck` rising edges, MSB first. Opcode 06h framed by exactly eight bits sets the write-enable latch when `cs_n` rises.
- R3: Opcode 05h makes the block drive the status byte on `dq_out`, MSB first, changing on `sck` falling edges after the eighth bit. The byte repeats for as long as clocks continue. Bit 0 is write-in-progress, bit 1 is write-enable latch, bits 4:2 mirror `protect[2:0]`, and bits 7:5 read 0.
- R4: Opcode C7h framed by exactly eight bits starts an erase when `cs_n` rises, provided the latch is set, `protect` is 000 and no erase runs. Write-in-progress then reads 1.
- R5: The erase lasts exactly ERASE_CYCLES system clocks of `erase_busy` high. Afterwards write-in-progress reads 0 and every array byte reads FFh.
- R6: The write-enable latch is 0 once the erase has begun and stays 0 after it.
- R7: A C7h command with the latch clear is ignored: no erase, array unchanged.
- R8: A C7h command with any protect bit set is ignored, and the latch stays 1.
- R9: A C7h command framed by 7 or by 9 bits is discarded, and the latch stays 1.
- R10: While write-in-progress is 1, 06h and C7h have no effect, but 05h still returns the status.
- R11: An unknown opcode changes neither the status nor the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| dq_in | input | 1 | Serial data into the block |
| dq_out | output | 1 | Serial status data out |
| protect | input | 3 | Block-protect bits shown in status |
| erase_busy | output | 1 | High while the erase strobe is applied |
| peek_addr | input | AW | Debug array read address |
| peek_data | output | 8 | Debug array read data |

## Verification
The erase opcode is sent under each gating condition: latch clear, a protect bit set, framing of seven and of nine bits, an erase already running, and the legal case. Each illegal case shows that one condition alone can block the erase, because the array keeps its reset pattern and the latch keeps its value. The legal erase is timed clock by clock on `erase_busy`, and the status is polled mid-erase to confirm the latch has already dropped. A run of unknown opcodes and a two-byte status read separate real decoding from opcode-independent behaviour and from a single-shot output shifter.

// File: rtl/flash_be_pkg.sv
package flash_be_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_BE   = 8'hC7;
    localparam logic [7:0] ERASED  = 8'hFF;

    typedef struct packed {
        logic [2:0] rsvd;
        logic [2:0] bp;
        logic       wel;
        logic       wip;
    } stat_t;

    typedef struct packed {
        logic       done;
        logic       exact8;
        logic [7:0] op;
    } frame_t;

    function automatic logic [7:0] init_byte(input int unsigned idx);
        return 8'((idx * 37 + 3) % 256);
    endfunction

endpackage

// File: rtl/fbe_spi_rx.sv
module fbe_spi_rx
    import flash_be_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       din,
    output frame_t     frm,
    output logic       byte_rdy,
    output logic [7:0] op_now,
    output logic       sck_fall,
    output logic       active
);
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [2:0] cs_p, sk_p;
    logic [1:0] d_p;
    logic       cs_s, cs_q, sk_rise, din_s;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p <= 3'b111;
            sk_p <= 3'b000;
            d_p  <= 2'b00;
        end else begin
            cs_p <= {cs_p[1:0], cs_n};
            sk_p <= {sk_p[1:0], sck};
            d_p  <= {d_p[0], din};
        end
    end

    assign cs_s     = cs_p[1];
    assign cs_q     = cs_p[2];
    assign din_s    = d_p[1];
    assign sk_rise  = sk_p[1] & ~sk_p[2];
    assign sck_fall = ~sk_p[1] & sk_p[2] & ~cs_s;
    assign active   = ~cs_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (cs_q && !cs_s) begin
            cnt <= '0;
        end else if (!cs_s && sk_rise) begin
            shreg <= {shreg[6:0], din_s};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    assign byte_rdy   = !cs_s && sk_rise && (cnt == CNT_W'(7));
    assign op_now     = {shreg[6:0], din_s};
    assign frm.done   = cs_s && !cs_q;
    assign frm.exact8 = (cnt == CNT_W'(8));
    assign frm.op     = shreg;

    // R9: every new frame starts its bit count from zero
    a_r9_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        (cs_q && !cs_s) |=> (cnt == '0));

endmodule

// File: rtl/fbe_ctrl.sv
module fbe_ctrl
    import flash_be_pkg::*;
#(
    parameter int unsigned ERASE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_t     frm,
    input  logic       byte_rdy,
    input  logic [7:0] op_now,
    input  logic       sck_fall,
    input  logic       active,
    input  logic [2:0] bp_in,
    output logic       erase_stb,
    output logic       miso
);
    localparam int CW = $clog2(ERASE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(ERASE_CYCLES - 1);

    logic          wip, wel;
    logic [2:0]    bp_q;
    logic [CW-1:0] cnt;
    logic          rd_mode, drive;
    logic [2:0]    ptr;
    stat_t         stat;
    logic          wren_go, be_go;

    assign stat    = '{rsvd: 3'b000, bp: bp_q, wel: wel, wip: wip};
    assign wren_go = frm.done && frm.exact8 && (frm.op == OP_WREN) && !wip;
    assign be_go   = frm.done && frm.exact8 && (frm.op == OP_BE) && !wip
                     && wel && (bp_q == 3'b000);

    always_ff @(posedge clk) begin
        if (rst) begin
            wip  <= 1'b0;
            wel  <= 1'b0;
            bp_q <= 3'b000;
            cnt  <= '0;
        end else begin
            bp_q <= bp_in;
            if (wip) begin
                if (cnt == '0) wel <= 1'b0;
                if (cnt == LAST) wip <= 1'b0;
                else             cnt <= cnt + 1'b1;
            end else if (be_go) begin
                wip <= 1'b1;
                cnt <= '0;
            end else if (wren_go) begin
                wel <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            rd_mode <= 1'b0;
            drive   <= 1'b0;
            ptr     <= '0;
        end else if (byte_rdy && op_now == OP_RDSR) begin
            rd_mode <= 1'b1;
            drive   <= 1'b0;
            ptr     <= '0;
        end else if (rd_mode && sck_fall) begin
            if (!drive) drive <= 1'b1;
            else        ptr   <= ptr + 1'b1;
        end
    end

    assign miso      = (rd_mode && drive) ? stat[3'd7 - ptr] : 1'b0;
    assign erase_stb = wip;

    // R4: an erase only begins from a set latch with no protection
    a_r4_start_legal: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> ($past(wel) && $past(bp_q) == 3'b000));
    // R6: latch is gone one clock into the erase
    a_r6_wel_drop: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |=> !wel);
    // R5: timer never runs past its last count
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R10: latch cannot be set while an erase is running
    a_r10_wel_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !$past(wip));

endmodule

// File: rtl/fbe_array.sv
module fbe_array
    import flash_be_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wipe,
    input  logic [AW-1:0] peek_addr,
    output logic [7:0]    peek_data
);
    logic [7:0] words [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)       words[i] <= init_byte(i);
            else if (wipe) words[i] <= ERASED;
        end
    end

    assign peek_data = words[peek_addr];

    // R5: at the end of the strobe both ends of the array are erased
    a_r5_array_full: assert property (@(posedge clk) disable iff (rst)
        $fell(wipe) |-> (words[0] == ERASED && words[DEPTH-1] == ERASED));

endmodule

// File: rtl/flash_bulk_erase_unit.sv
module flash_bulk_erase_unit
    import flash_be_pkg::*;
#(
    parameter int unsigned ERASE_CYCLES = 64,
    parameter int unsigned DEPTH        = 16,
    parameter int unsigned AW           = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          dq_in,
    output logic          dq_out,
    input  logic [2:0]    protect,
    output logic          erase_busy,
    input  logic [AW-1:0] peek_addr,
    output logic [7:0]    peek_data
);
    frame_t     frm;
    logic       byte_rdy, sck_fall, active, stb;
    logic [7:0] op_now;

    fbe_spi_rx u_rx (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .din(dq_in),
        .frm(frm), .byte_rdy(byte_rdy), .op_now(op_now),
        .sck_fall(sck_fall), .active(active)
    );

    fbe_ctrl #(.ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .frm(frm), .byte_rdy(byte_rdy),
        .op_now(op_now), .sck_fall(sck_fall), .active(active),
        .bp_in(protect), .erase_stb(stb), .miso(dq_out)
    );

    fbe_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .rst(rst), .wipe(stb),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    assign erase_busy = stb;

endmodule

// File: tb/flash_bulk_erase_unit_bench.sv
module flash_bulk_erase_unit_bench;
    localparam int N     = 1000;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int HP    = 6;

    logic clk = 0, rst = 1, cs_n = 1, sck = 0, dq_in = 0;
    logic [2:0] protect = 3'b000;
    logic [AW-1:0] peek_addr = '0;
    logic dq_out, erase_busy;
    logic [7:0] peek_data;
    int errors = 0, checks = 0, busy_cycles = 0;

    always #2 clk = ~clk;

    flash_bulk_erase_unit #(.ERASE_CYCLES(N), .DEPTH(DEPTH), .AW(AW)) u_flash_bulk_erase_unit (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
        .dq_out(dq_out), .protect(protect), .erase_busy(erase_busy),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    always @(negedge clk) if (erase_busy) busy_cycles++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] op, input int nbits, input int nread,
                        output logic [15:0] rd);
        rd = '0;
        @(negedge clk);
        cs_n = 0;
        wait_clk(HP);
        for (int i = 0; i < nbits; i++) begin
            dq_in = (i < 8) ? op[7-i] : 1'b0;
            wait_clk(HP);
            sck = 1;
            wait_clk(HP);
            sck = 0;
        end
        for (int i = 0; i < nread * 8; i++) begin
            wait_clk(HP);
            rd = {rd[14:0], dq_out};
            sck = 1;
            wait_clk(HP);
            sck = 0;
        end
        wait_clk(HP);
        cs_n = 1;
        wait_clk(8);
    endtask

    task automatic read_status(output logic [7:0] s);
        logic [15:0] rd;
        xfer(8'h05, 8, 1, rd);
        s = rd[7:0];
    endtask

    task automatic check_array(input string req, input bit erased);
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            peek_addr = AW'(i);
            @(negedge clk);
            if (peek_data != (erased ? 8'hFF : 8'((i * 37 + 3) % 256))) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        check("R1 busy", erase_busy, 0);
        read_status(s);
        check("R1 status", s, 8'h00);
        check_array("R1 array", 0);
    endtask

    task automatic t_no_wel;
        logic [15:0] rd;
        logic [7:0] s;
        xfer(8'hC7, 8, 0, rd);
        wait_clk(20);
        check("R7 busy", erase_busy, 0);
        read_status(s);
        check("R7 status", s, 8'h00);
        check_array("R7 array", 0);
    endtask

    task automatic t_unknown;
        logic [15:0] rd;
        logic [7:0] s;
        xfer(8'h5A, 8, 0, rd);
        xfer(8'h04, 8, 0, rd);
        read_status(s);
        check("R11 status", s, 8'h00);
        check_array("R11 array", 0);
    endtask

    task automatic t_wren;
        logic [15:0] rd;
        logic [7:0] s;
        xfer(8'h06, 8, 0, rd);
        read_status(s);
        check("R2 wel set", s, 8'h02);
        xfer(8'h05, 8, 2, rd);
        check("R3 repeat", rd, 16'h0202);
    endtask

    task automatic t_protect;
        logic [15:0] rd;
        logic [7:0] s;
        protect = 3'b010;
        wait_clk(4);
        read_status(s);
        check("R3 bp field", s, 8'h0A);
        xfer(8'hC7, 8, 0, rd);
        wait_clk(20);
        check("R8 busy", erase_busy, 0);
        read_status(s);
        check("R8 wel kept", s, 8'h0A);
        protect = 3'b100;
        wait_clk(4);
        xfer(8'hC7, 8, 0, rd);
        read_status(s);
        check("R8 bp2 blocks", s, 8'h12);
        protect = 3'b000;
        wait_clk(4);
        check_array("R8 array", 0);
    endtask

    task automatic t_bad_len;
        logic [15:0] rd;
        logic [7:0] s;
        xfer(8'hC7, 7, 0, rd);
        wait_clk(20);
        check("R9 seven bits", erase_busy, 0);
        xfer(8'hC7, 9, 0, rd);
        wait_clk(20);
        check("R9 nine bits", erase_busy, 0);
        read_status(s);
        check("R9 wel kept", s, 8'h02);
        check_array("R9 array", 0);
    endtask

    task automatic t_erase;
        logic [15:0] rd;
        logic [7:0] s;
        busy_cycles = 0;
        xfer(8'hC7, 8, 0, rd);
        check("R4 started", erase_busy, 1);
        read_status(s);
        check("R6 R10 poll", s, 8'h01);
        xfer(8'h06, 8, 0, rd);
        xfer(8'hC7, 8, 0, rd);
        read_status(s);
        check("R10 wren ignored", s, 8'h01);
        while (erase_busy) @(negedge clk);
        wait_clk(4);
        check("R5 duration", busy_cycles, N);
        read_status(s);
        check("R5 wip clear", s, 8'h00);
        check_array("R5 array", 1);
        wait_clk(20);
        check("R10 no restart", busy_cycles, N);
    endtask

    initial begin
        wait_clk(5);
        rst = 0;
        wait_clk(5);
        t_reset();
        t_no_wel();
        t_unknown();
        t_wren();
        t_protect();
        t_bad_len();
        t_erase();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule